// File: doc/BRIEF.md
# Handshake Data Transfer Bridge

This block carries one multi-bit word at a time from a source clock domain to an unrelated destination clock domain. The source side registers the word on a load strobe, holds it still, and raises a request level that is synchronized into the destination domain. When the destination sees the synchronized request, it captures the word from the held source register, emits a one-cycle valid pulse with the word, and returns an acknowledge level through a synchronizer. The request drops once the acknowledge is seen, and the acknowledge drops once the request is seen low. This completes a four-phase cycle. The source reports `busy_o` for the whole cycle and ignores loads during it.

A parameter adds a third line, a ready level, that runs from destination to source. Ready falls when the receiver takes a word. It rises again only after the receiver has seen the request low. The sender will not start a new word until it has seen ready. Every word pays the full synchronizer latency in both directions, so the bridge suits control words and other infrequent data, not streams.

Top module: `hs_bridge`

## Requirements
- R1: After reset `data_o` is 0 and `data_valid_o` is 0. With `USE_READY`=0, `busy_o` is 0 from reset.
- R2: A `load_i` high at a source edge where `busy_o` is low is accepted: `data_i` is registered, and `busy_o` is high from that edge until the handshake completes.
- R3: A `load_i` while `busy_o` is high is ignored. It produces no extra `data_valid_o` pulse, and its data never appears on `data_o`.
- R4: Each accepted word appears on `data_o` together with a `data_valid_o` pulse that lasts exactly one destination cycle. There is one pulse per accepted word, in order.
- R5: `data_o` changes only in a cycle where `data_valid_o` is high. Changes on `data_i` without an accepted load have no effect at the outputs.
- R6: The sender keeps its registered word unchanged while busy. It raises the request one source cycle after registering the word, so the word is stable for at least two source edges before the request.
- R7: The handshake is four-phase. The request rises only while the synchronized acknowledge is low, and falls only after the acknowledge is seen high. The acknowledge falls only after the synchronized request is seen low.
- R8: With `USE_READY`=1, ready is low whenever the acknowledge is high. Ready is high only if the synchronized request was low in the previous destination cycle. The request rises only while the synchronized ready is high.
- R9: `busy_o` falls only after the acknowledge is seen low in the source domain, and so only after the word's `data_valid_o` pulse.
- R10: With `USE_READY`=1, `busy_o` is high from reset until the synchronized ready arrives, and is high again after each transfer until ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| dst_clk_i | input | 1 | Destination domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| load_i | input | 1 | Source strobe: take `data_i` when not busy |
| data_i | input | DATA_W | Source word |
| busy_o | output | 1 | Source: a transfer is in flight or the receiver is not ready |
| data_o | output | DATA_W | Destination word, held between pulses |
| data_valid_o | output | 1 | Destination one-cycle pulse marking a new word |

## Verification
Suppose the sender's state slips: it drops the request early, or it re-opens for loads before the acknowledge falls. The ports then show a missing or a doubled `data_valid_o` pulse, or a word on `data_o` that is not the one accepted. This shows at the end of that same transfer, a few destination cycles after the load. If the receiver's state is wrong, the same pulse goes wrong, or `busy_o` stays high forever, which the run detects as a hang. A ready line stuck low in three-wire mode shows as `busy_o` never falling after reset. Spamming loads while busy, and changing `data_i` while idle, expose any path that updates the held word when it should not.

// File: rtl/hs_bridge_pkg.sv
package hs_bridge_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SETUP,
    TX_REQ,
    TX_RELEASE
  } tx_state_e;

  typedef enum logic {
    RX_IDLE,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_sender.sv
module hs_sender
  import hs_bridge_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit USE_READY = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_s_i,
  input  logic              rdy_s_i,
  output logic              req_o,
  output logic [DATA_W-1:0] word_o,
  output logic              busy_o
);
  tx_state_e         st_q;
  logic              req_q;
  logic [DATA_W-1:0] word_q;
  logic              blocked;

  // in two-wire mode the ready line is disregarded
  assign blocked = USE_READY && !rdy_s_i;
  assign busy_o  = (st_q != TX_IDLE) || blocked;
  assign req_o   = req_q;
  assign word_o  = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      req_q  <= 1'b0;
      word_q <= '0;
    end else begin
      unique case (st_q)
        TX_IDLE: if (load_i && !busy_o) begin
          word_q <= data_i;
          st_q   <= TX_SETUP;
        end
        // one extra source edge of data setup before the request
        TX_SETUP: begin
          req_q <= 1'b1;
          st_q  <= TX_REQ;
        end
        TX_REQ: if (ack_s_i) begin
          req_q <= 1'b0;
          st_q  <= TX_RELEASE;
        end
        TX_RELEASE: if (!ack_s_i) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
  import hs_bridge_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit USE_READY = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_s_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              ack_o,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  rx_state_e         st_q, st_d;
  logic              ack_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RX_IDLE: if (req_s_i)  st_d = RX_HOLD;
      RX_HOLD: if (!req_s_i) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      valid_q <= 1'b0;
      if (st_q == RX_IDLE && req_s_i) begin
        data_q  <= word_i;  // word held stable by sender while request is high
        valid_q <= 1'b1;
        ack_q   <= 1'b1;
      end else if (st_q == RX_HOLD && !req_s_i) begin
        ack_q <= 1'b0;
      end
    end
  end

  generate
    if (USE_READY) begin : g_rdy
      logic rdy_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdy_q <= 1'b0;
        else         rdy_q <= (st_d == RX_IDLE) && !req_s_i;
      end
      assign rdy_o = rdy_q;
    end else begin : g_no_rdy
      assign rdy_o = 1'b0;
    end
  endgenerate

  assign ack_o   = ack_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/hs_bridge.sv
module hs_bridge #(
  parameter int DATA_W      = 16,
  parameter bit USE_READY   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk_i,
  input  logic              dst_clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o
);
  logic              src_req;
  logic              src_ack_s;
  logic              src_rdy_s;
  logic [DATA_W-1:0] src_word;
  logic              dst_req_s;
  logic              dst_ack;
  logic              dst_rdy;

  hs_sender #(.DATA_W(DATA_W), .USE_READY(USE_READY)) u_tx (
    .clk_i   (src_clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .data_i  (data_i),
    .ack_s_i (src_ack_s),
    .rdy_s_i (src_rdy_s),
    .req_o   (src_req),
    .word_o  (src_word),
    .busy_o  (busy_o)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
    .clk_i (dst_clk_i), .rst_ni (rst_ni), .d_i (src_req), .q_o (dst_req_s)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk_i (src_clk_i), .rst_ni (rst_ni), .d_i (dst_ack), .q_o (src_ack_s)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_rdy (
    .clk_i (src_clk_i), .rst_ni (rst_ni), .d_i (dst_rdy), .q_o (src_rdy_s)
  );

  hs_receiver #(.DATA_W(DATA_W), .USE_READY(USE_READY)) u_rx (
    .clk_i   (dst_clk_i),
    .rst_ni  (rst_ni),
    .req_s_i (dst_req_s),
    .word_i  (src_word),
    .ack_o   (dst_ack),
    .rdy_o   (dst_rdy),
    .data_o  (data_o),
    .valid_o (data_valid_o)
  );
endmodule

// File: rtl/hs_bridge_chk.sv
module hs_bridge_chk #(
  parameter int DATA_W    = 16,
  parameter bit USE_READY = 1'b1
) (
  input logic              src_clk_i,
  input logic              dst_clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic [DATA_W-1:0] data_o,
  input logic              data_valid_o,
  input logic              src_req,
  input logic              src_ack_s,
  input logic              src_rdy_s,
  input logic [DATA_W-1:0] src_word,
  input logic              dst_req_s,
  input logic              dst_ack,
  input logic              dst_rdy
);
  // R4
  valid_pulse_chk: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);

  // R5
  out_hold_chk: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    !data_valid_o |-> $stable(data_o));

  // R6
  word_hold_chk: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $past(src_req || src_ack_s)) |-> $stable(src_word));

  // R2
  req_in_busy_chk: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    src_req |-> busy_o);

  // R7
  req_rise_chk: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $rose(src_req) |-> !src_ack_s);

  // R7
  req_fall_chk: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $fell(src_req) |-> src_ack_s);

  // R7
  ack_fall_chk: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    $fell(dst_ack) |-> !dst_req_s);

  // R9
  busy_fall_chk: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !src_ack_s);

  generate
    if (USE_READY) begin : g_rdy_chk
      // R8
      rdy_vs_ack_chk: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
        !(dst_rdy && dst_ack));

      // R8
      rdy_after_req_low_chk: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
        dst_rdy |-> !$past(dst_req_s));

      // R8
      req_needs_rdy_chk: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
        $rose(src_req) |-> src_rdy_s);
    end
  endgenerate
endmodule

bind hs_bridge hs_bridge_chk #(.DATA_W(DATA_W), .USE_READY(USE_READY)) u_chk (
  .src_clk_i    (src_clk_i),
  .dst_clk_i    (dst_clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .data_o       (data_o),
  .data_valid_o (data_valid_o),
  .src_req      (src_req),
  .src_ack_s    (src_ack_s),
  .src_rdy_s    (src_rdy_s),
  .src_word     (src_word),
  .dst_req_s    (dst_req_s),
  .dst_ack      (dst_ack),
  .dst_rdy      (dst_rdy)
);

// File: tb/hs_bridge_test.sv
`timescale 1ns/1ps
module hs_bridge_test;
  localparam int W = 16;

  logic          sclk = 1'b0;
  logic          dclk = 1'b0;
  logic          rst_ni = 1'b0;
  real           dst_half = 5.5;
  logic          ld   [2];
  logic [W-1:0]  din  [2];
  logic          busy [2];
  logic [W-1:0]  dout [2];
  logic          dv   [2];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  bit           pending [2];
  logic [W-1:0] exp_w   [2];
  logic [W-1:0] last_out[2];
  bit           dv_prev [2];
  bit           busy_prev[2];

  always #4 sclk = ~sclk;  // 125 MHz source clock
  initial forever #(dst_half) dclk = ~dclk;

  hs_bridge #(.DATA_W(W), .USE_READY(1'b1)) uut (
    .src_clk_i(sclk), .dst_clk_i(dclk), .rst_ni(rst_ni),
    .load_i(ld[0]), .data_i(din[0]), .busy_o(busy[0]),
    .data_o(dout[0]), .data_valid_o(dv[0])
  );

  hs_bridge #(.DATA_W(W), .USE_READY(1'b0)) uut_2w (
    .src_clk_i(sclk), .dst_clk_i(dclk), .rst_ni(rst_ni),
    .load_i(ld[1]), .data_i(din[1]), .busy_o(busy[1]),
    .data_o(dout[1]), .data_valid_o(dv[1])
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [W-1:0] pick_word(input int mode);
    case (mode)
      0: return '0;
      1: return '1;
      2: return {W/2{2'b10}};
      default: return W'($urandom);
    endcase
  endfunction

  // destination-side scoreboard
  always @(negedge dclk) begin
    if (rst_ni) begin
      for (int k = 0; k < 2; k++) begin
        if (dv[k]) begin
          chk(pending[k], "R3", "pulse without accepted load", 1, 0);
          if (pending[k]) chk(dout[k] == exp_w[k], "R4", "delivered word", dout[k], exp_w[k]);
          chk(!dv_prev[k], "R4", "valid pulse width", 2, 1);
          pending[k] = 1'b0;
          last_out[k] = dout[k];
        end else begin
          chk(dout[k] == last_out[k], "R5", "data_o held without valid", dout[k], last_out[k]);
        end
        dv_prev[k] = dv[k];
      end
    end
  end

  // source-side busy monitor
  always @(negedge sclk) begin
    if (rst_ni) begin
      for (int k = 0; k < 2; k++) begin
        if (busy_prev[k] && !busy[k])
          chk(!pending[k], "R9", "busy fell before word delivered", 1, 0);
        busy_prev[k] = busy[k];
      end
    end
  end

  // watchdog
  always @(posedge sclk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_idle(input int k);
    while (pending[k] || busy[k]) @(negedge sclk);
  endtask

  task automatic send(input int k, input logic [W-1:0] word, input int spam, input int gap);
    repeat (gap) begin
      @(negedge sclk);
      din[k] = W'($urandom);  // R5: data_i churn without load
    end
    @(negedge sclk);
    while (busy[k]) @(negedge sclk);
    ld[k] = 1'b1;
    din[k] = word;
    pending[k] = 1'b1;
    exp_w[k] = word;
    @(negedge sclk);
    ld[k] = 1'b0;
    // R2: busy from the accepting edge
    chk(busy[k] == 1'b1, "R2", "busy after accepted load", busy[k], 1);
    for (int i = 0; i < spam; i++) begin
      if (busy[k]) begin
        ld[k] = 1'b1;  // R3: ignored load while busy
        din[k] = ~word;
      end
      @(negedge sclk);
      ld[k] = 1'b0;
    end
    wait_idle(k);
  endtask

  task automatic run_phase(input int k, input int n);
    // directed corners: fixed patterns, back-to-back, heavy spam
    send(k, pick_word(0), 0, 0);
    send(k, pick_word(1), 0, 0);
    send(k, pick_word(2), 3, 0);
    send(k, pick_word(1), 3, 2);
    for (int i = 0; i < n; i++)
      send(k, pick_word(3), int'($urandom_range(0, 3)), int'($urandom_range(0, 4)));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 2; k++) begin
      ld[k] = 1'b0; din[k] = '0; pending[k] = 1'b0;
      exp_w[k] = '0; last_out[k] = '0; dv_prev[k] = 1'b0; busy_prev[k] = 1'b0;
    end
    repeat (3) @(negedge sclk);
    rst_ni = 1'b1;
    #0.5;
    for (int k = 0; k < 2; k++) begin
      chk(dout[k] == '0, "R1", "data_o after reset", dout[k], 0);
      chk(dv[k] == 1'b0, "R1", "valid after reset", dv[k], 0);
    end
    chk(busy[1] == 1'b0, "R1", "two-wire busy after reset", busy[1], 0);
    // R10: three-wire bridge is busy until ready crosses over
    chk(busy[0] == 1'b1, "R10", "three-wire busy before ready", busy[0], 1);
    begin
      int n = 0;
      while (busy[0] && n < 40) begin @(negedge sclk); n++; end
      chk(busy[0] == 1'b0, "R10", "ready arrives after reset", busy[0], 0);
    end
    // R3/R5: idle with data churn and no load changes nothing
    repeat (10) begin
      @(negedge sclk);
      din[0] = W'($urandom); din[1] = W'($urandom);
    end
    for (int k = 0; k < 2; k++)
      chk(dout[k] == '0, "R5", "idle data_i churn", dout[k], 0);

    // slower destination clock
    run_phase(0, 30);
    run_phase(1, 30);
    // faster destination clock
    repeat (4) @(negedge sclk);
    dst_half = 2.5;
    repeat (4) @(negedge sclk);
    run_phase(0, 30);
    run_phase(1, 30);

    // R8/R10: after a transfer the three-wire sender waits for ready again
    send(0, pick_word(3), 0, 0);
    chk(busy[0] == 1'b0, "R8", "ready restored after transfer", busy[0], 0);
    repeat (10) @(negedge sclk);
    for (int k = 0; k < 2; k++)
      chk(!pending[k], "R4", "all words delivered", pending[k], 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule